// File: doc/BRIEF.md
# Four-Lane Folding CRC32C Engine

This block computes a CRC32C over a stream of 128-bit words. It takes one word per clock. It spreads the words round-robin over four 128-bit lane accumulators. Each lane is advanced by multiplying it by x^512 modulo the CRC polynomial and adding the new word. The block does not divide by the polynomial at every word. Each fold uses two 64x32 carry-less products with precomputed remainders of powers of x, and the results are combined with XOR. Only one true modular reduction takes place, at the very end of the stream.

When the final word is accepted, the block stops taking input. It then merges the four lanes in three folding steps and reduces the resulting 128-bit value to the 32-bit CRC with a bit-serial divider. The divider handles `RED_BITS` bits per cycle. A single-cycle strobe presents the result, and the next stream may start in the following cycle. The caller supplies the starting CRC value together with the first word. The block applies no pre-inversion or post-inversion, so the caller applies those conventions outside the block.

Top module: `crc_fold_engine`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `inReady` is 1 and `crcValid` is 0.
- R2: The CRC is the reflected CRC32C remainder, with no input or output inversion, of the stream bytes. The reflected polynomial is 0x82F63B78, equivalent to the normal form 0x1EDC6F41. Words are taken in order. Byte b of a word is bits [8b+7:8b], bytes are taken from b=0 upward, and the bits within a byte are taken LSB first. The byte-wise update is `c ^= byte`, followed by eight steps of `c = c[0] ? (c>>1)^0x82F63B78 : c>>1`.
- R3: `crcInit` is sampled only together with the first word of a stream. Its value while later words are accepted has no effect on the result.
- R4: While a stream is being delivered, `inReady` stays 1, so one word can be accepted on every clock edge.
- R5: A stream holds a positive multiple of four words. `inLast` may be 1 only on a word whose zero-based position is 4k+3, and it ends the stream.
- R6: From the edge that accepts the last word until the `crcValid` cycle, `inReady` is 0. Words offered during that time are not taken and do not affect the result.
- R7: `crcValid` is high for exactly one cycle. That cycle begins 3 + 128/`RED_BITS` clock edges after the edge that accepted the last word, and `crcOut` holds the CRC during it.
- R8: In the cycle after `crcValid`, `inReady` is 1 again. A new stream is then computed independently of earlier streams.
- R9: Cycles with `inValid` low inside a stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A data word is offered |
| inReady | output | 1 | The block can take a word on this edge |
| inData | input | 128 | Data word; byte 0 is in the low bits |
| inLast | input | 1 | Marks the final word of a stream |
| crcInit | input | 32 | Starting CRC value, sampled with the first word |
| crcValid | output | 1 | One-cycle strobe: `crcOut` holds the result |
| crcOut | output | 32 | Resulting CRC (reflected form) |

## Verification
The bench builds the engine with `RED_BITS` set to 16. The final division therefore runs in eight steps, and the 11-edge result latency can be checked exactly. The default fold constants come from the package's power-of-x function. Streams of 4, 8 and 32 words therefore exercise the first-round lane loading, several x^512 steady-state folds, and all three merge folds against an independent byte-serial model. Random, all-zero and all-one data is covered. Junk words offered while the engine is busy and gaps inside a stream reach the input-ignore paths.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;

  localparam int WORD_W = 128;
  localparam int HALF_W = 64;
  localparam int CRC_W  = 32;
  localparam int PROD_W = HALF_W + CRC_W - 1;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;       // write accepted word into a lane
    logic              firstRound; // lane load without folding
    logic [LANE_W-1:0] laneSel;    // lane receiving the word
    logic              mergeEn;    // one merge fold this cycle
    logic [1:0]        mergeSel;   // 0: L0=f128(L0)^L1, 1: L2=f128(L2)^L3, 2: reduce in f256(L0)^L2
    logic              redStep;    // one step of the final division
  } ctrl_t;

  // x^m mod poly, normal bit order (bit i = coefficient of x^i)
  function automatic logic [CRC_W-1:0] xPowMod(input int m, input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    logic             top;
    r = 1;
    for (int i = 0; i < m; i++) begin
      top = r[CRC_W-1];
      r   = {r[CRC_W-2:0], 1'b0} ^ ({CRC_W{top}} & poly);
    end
    return r;
  endfunction

  function automatic logic [PROD_W-1:0] clmul(input logic [HALF_W-1:0] a, input logic [CRC_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = '0;
    for (int i = 0; i < CRC_W; i++)
      if (b[i]) p ^= {{(CRC_W-1){1'b0}}, a} << i;
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] rev128(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] o;
    for (int i = 0; i < WORD_W; i++) o[i] = v[WORD_W-1-i];
    return o;
  endfunction

  function automatic logic [CRC_W-1:0] rev32(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] o;
    for (int i = 0; i < CRC_W; i++) o[i] = v[CRC_W-1-i];
    return o;
  endfunction

endpackage

// File: rtl/crc_fold_dp.sv
module crc_fold_dp
  import crc_fold_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY     = 32'h1EDC6F41,
  parameter int               RED_BITS = 8,
  parameter logic [CRC_W-1:0] K512_HI  = 32'h0,
  parameter logic [CRC_W-1:0] K512_LO  = 32'h0,
  parameter logic [CRC_W-1:0] K256_HI  = 32'h0,
  parameter logic [CRC_W-1:0] K256_LO  = 32'h0,
  parameter logic [CRC_W-1:0] K128_HI  = 32'h0,
  parameter logic [CRC_W-1:0] K128_LO  = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] inData,
  input  logic [CRC_W-1:0]  crcInit,
  output logic [CRC_W-1:0]  crcOut
);

  logic [WORD_W-1:0] lane [LANES];
  logic [WORD_W-1:0] wordN, initTerm;
  logic [WORD_W-1:0] foldSrc, foldOut, mergeAdd;
  logic [CRC_W-1:0]  kHi, kLo;
  logic [WORD_W-1:0] redBuf;
  logic [CRC_W-1:0]  redCrc, redNext;

  // Internal arithmetic uses normal bit order; reflection is wiring only
  assign wordN    = rev128(inData);
  assign initTerm = {rev32(crcInit), {(WORD_W-CRC_W){1'b0}}};

  // Shared folding unit: select source and constant pair
  always_comb begin
    foldSrc  = lane[ctl.laneSel];
    kHi      = K512_HI;
    kLo      = K512_LO;
    mergeAdd = lane[1];
    if (ctl.mergeEn) begin
      unique case (ctl.mergeSel)
        2'd0:    begin foldSrc = lane[0]; kHi = K128_HI; kLo = K128_LO; mergeAdd = lane[1]; end
        2'd1:    begin foldSrc = lane[2]; kHi = K128_HI; kLo = K128_LO; mergeAdd = lane[3]; end
        default: begin foldSrc = lane[0]; kHi = K256_HI; kLo = K256_LO; mergeAdd = lane[2]; end
      endcase
    end
  end

  assign foldOut = {{(WORD_W-PROD_W){1'b0}},
                    clmul(foldSrc[WORD_W-1:HALF_W], kHi) ^ clmul(foldSrc[HALF_W-1:0], kLo)};

  // Lane accumulators
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic wordHit, mergeHit;
    assign wordHit  = ctl.wrEn && (ctl.laneSel == LANE_W'(g));
    assign mergeHit = ctl.mergeEn && ((g == 0 && ctl.mergeSel == 2'd0) ||
                                      (g == 2 && ctl.mergeSel == 2'd1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lane[g] <= '0;
      else if (wordHit) begin
        if (ctl.firstRound)
          lane[g] <= (g == 0) ? (wordN ^ initTerm) : wordN;
        else
          lane[g] <= foldOut ^ wordN;
      end else if (mergeHit)
        lane[g] <= foldOut ^ mergeAdd;
    end
  end

  // Final division: RED_BITS message bits per step
  always_comb begin
    logic fb;
    redNext = redCrc;
    for (int i = 0; i < RED_BITS; i++) begin
      fb      = redNext[CRC_W-1] ^ redBuf[WORD_W-1-i];
      redNext = {redNext[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redBuf <= '0;
      redCrc <= '0;
    end else if (ctl.mergeEn && ctl.mergeSel == 2'd2) begin
      redBuf <= foldOut ^ mergeAdd;
      redCrc <= '0;
    end else if (ctl.redStep) begin
      redBuf <= redBuf << RED_BITS;
      redCrc <= redNext;
    end
  end

  assign crcOut = rev32(redCrc);

  AST_WRITE_NOT_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrEn && (ctl.mergeEn || ctl.redStep))); // R6
  AST_REDUCE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mergeEn && ctl.mergeSel == 2'd2) |=> ctl.redStep); // R7

endmodule

// File: rtl/crc_fold_ctrl.sv
module crc_fold_ctrl
  import crc_fold_pkg::*;
#(
  parameter int RED_STEPS = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inLast,
  output logic  inReady,
  output logic  crcValid,
  output ctrl_t ctl
);

  localparam int CNT_W = $clog2(RED_STEPS + 1);

  typedef enum logic [2:0] {S_STREAM, S_M0, S_M1, S_M2, S_RED, S_DONE} state_t;

  state_t            state;
  logic [LANE_W-1:0] laneIdx;
  logic              firstRound;
  logic [CNT_W-1:0]  redCnt;
  logic              accept;

  assign inReady  = (state == S_STREAM);
  assign crcValid = (state == S_DONE);
  assign accept   = inValid && inReady;

  always_comb begin
    ctl            = '0;
    ctl.wrEn       = accept;
    ctl.firstRound = firstRound;
    ctl.laneSel    = laneIdx;
    ctl.mergeEn    = (state == S_M0) || (state == S_M1) || (state == S_M2);
    ctl.mergeSel   = (state == S_M0) ? 2'd0 : (state == S_M1) ? 2'd1 : 2'd2;
    ctl.redStep    = (state == S_RED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_STREAM;
      laneIdx    <= '0;
      firstRound <= 1'b1;
      redCnt     <= '0;
    end else begin
      unique case (state)
        S_STREAM: if (accept) begin
          laneIdx <= laneIdx + 1'b1;
          if (laneIdx == LANE_W'(LANES-1)) firstRound <= 1'b0;
          if (inLast) begin
            state      <= S_M0;
            laneIdx    <= '0;
            firstRound <= 1'b1;
          end
        end
        S_M0: state <= S_M1;
        S_M1: state <= S_M2;
        S_M2: begin
          state  <= S_RED;
          redCnt <= '0;
        end
        S_RED: begin
          redCnt <= redCnt + 1'b1;
          if (redCnt == CNT_W'(RED_STEPS-1)) state <= S_DONE;
        end
        default: state <= S_STREAM;
      endcase
    end
  end

  AST_LAST_ON_LANE3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inLast) |-> (laneIdx == LANE_W'(LANES-1))); // R5
  AST_STALL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inLast) |=> !inReady); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    crcValid |=> !crcValid); // R7
  AST_RESUME_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    crcValid |=> inReady); // R8

endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine
  import crc_fold_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY     = 32'h1EDC6F41,
  parameter int               RED_BITS = 8,
  parameter logic [CRC_W-1:0] K512_HI  = xPowMod(512 + HALF_W, POLY),
  parameter logic [CRC_W-1:0] K512_LO  = xPowMod(512, POLY),
  parameter logic [CRC_W-1:0] K256_HI  = xPowMod(256 + HALF_W, POLY),
  parameter logic [CRC_W-1:0] K256_LO  = xPowMod(256, POLY),
  parameter logic [CRC_W-1:0] K128_HI  = xPowMod(128 + HALF_W, POLY),
  parameter logic [CRC_W-1:0] K128_LO  = xPowMod(128, POLY)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic [127:0]  inData,
  input  logic          inLast,
  input  logic [31:0]   crcInit,
  output logic          crcValid,
  output logic [31:0]   crcOut
);

  localparam int RED_STEPS = WORD_W / RED_BITS;

  ctrl_t ctl;

  crc_fold_ctrl #(.RED_STEPS(RED_STEPS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .crcValid (crcValid),
    .ctl      (ctl)
  );

  crc_fold_dp #(
    .POLY(POLY), .RED_BITS(RED_BITS),
    .K512_HI(K512_HI), .K512_LO(K512_LO),
    .K256_HI(K256_HI), .K256_LO(K256_LO),
    .K128_HI(K128_HI), .K128_LO(K128_LO)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .crcInit (crcInit),
    .crcOut  (crcOut)
  );

endmodule

// File: tb/sim_crc_fold_engine.sv
module sim_crc_fold_engine;

  localparam int CLK_PERIOD = 10;
  localparam int RED_BITS   = 16;
  localparam int LATENCY    = 3 + 128 / RED_BITS;
  localparam int MAX_WORDS  = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inData = '0;
  logic         inLast = 1'b0;
  logic [31:0]  crcInit = '0;
  logic         crcValid;
  logic [31:0]  crcOut;

  int compared = 0;
  int mismatched = 0;
  logic [127:0] words [MAX_WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_fold_engine #(.RED_BITS(RED_BITS)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .crcInit(crcInit),
    .crcValid(crcValid), .crcOut(crcOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Byte-serial reflected model (R2)
  function automatic logic [31:0] refCrc(input logic [31:0] init, input int n);
    logic [31:0] c;
    c = init;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 16; b++) begin
        c ^= {24'b0, words[w][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
      end
    return c;
  endfunction

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(inReady == 1'b1, "R1 ready in reset", 32'(inReady), 32'd1);
    check(crcValid == 1'b0, "R1 valid in reset", 32'(crcValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1 && crcValid == 1'b0, "R1 after release",
          {30'b0, inReady, crcValid}, 32'h2);
  endtask

  // mode 0: random, 1: zeros, 2: ones
  task automatic runStream(input string name, input int n, input logic [31:0] init,
                           input int mode, input bit gaps, input bit junk);
    int stalls = 0;
    int cyc = 1;
    int readyBusy = 0;
    logic [31:0] expCrc;
    for (int w = 0; w < n; w++)
      words[w] = (mode == 1) ? '0 : (mode == 2) ? '1 :
                 {$urandom(), $urandom(), $urandom(), $urandom()};
    expCrc = refCrc(init, n);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      if (gaps && (w % 3 == 1)) begin
        inValid = 1'b0;
        inData  = '1;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = words[w];
      inLast  = (w == n - 1);
      crcInit = (w == 0) ? init : $urandom(); // R3: only first word's init counts
      while (!inReady) begin stalls++; @(negedge clk); end
      @(posedge clk);
    end
    @(negedge clk);
    inValid = junk;
    inData  = {4{32'hDEADBEEF}};
    inLast  = 1'b1;
    while (!crcValid && cyc < 200) begin
      if (inReady) readyBusy++;
      @(negedge clk);
      cyc++;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    check(stalls == 0, {"R4 no stall ", name}, 32'(stalls), 32'd0);
    check(readyBusy == 0, {"R6 ready low while busy ", name}, 32'(readyBusy), 32'd0);
    check(crcOut == expCrc, {"R2 R3 R5 R6 R9 crc ", name}, crcOut, expCrc);
    check(cyc - 1 == LATENCY, {"R7 latency ", name}, 32'(cyc - 1), 32'(LATENCY));
    @(negedge clk);
    check(crcValid == 1'b0, {"R7 strobe one cycle ", name}, 32'(crcValid), 32'd0);
    check(inReady == 1'b1, {"R8 ready resumes ", name}, 32'(inReady), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    testReset();
    runStream("4w random", 4, 32'hFFFFFFFF, 0, 1'b0, 1'b0);
    runStream("8w zeros", 8, 32'hFFFFFFFF, 1, 1'b0, 1'b0);
    runStream("8w ones", 8, 32'h12345678, 2, 1'b0, 1'b1);
    runStream("32w random", 32, 32'h0BADF00D, 0, 1'b0, 1'b0);
    runStream("32w gaps", 32, 32'h00000000, 0, 1'b1, 1'b1);
    runStream("4w back-to-back", 4, 32'hA5A5A5A5, 0, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule